// File: doc/BRIEF.md
# Miss History Log Recorder

This block keeps the miss history of one core (or one hardware thread) as a circular log in main memory. Each retire-time address event comes with a kind and a wrong-path flag. Only correct-path off-chip load misses and prefetch-buffer hits are kept. A kept address goes into the next free slot of an on-chip staging line that holds `SLOTS` entries. When the staging line is full, it is handed to the memory side as a single line write tagged with its line index. Line indices wrap modulo `LINES`, so the log never holds addresses from another core.

For every kept address, the block offers one index-table update the cycle after it accepts the address. The offer carries the address and its log position, `{line index, slot index}`. The offer is advisory and cannot push back: the downstream sampling filter may take it or drop it.

A separate mark request can set the stream-end bit of an entry while that entry is still in the staging line. Each stored entry is `{end_mark, address}`, with the mark in the most significant bit.

Two interfaces use valid/ready:

- **Retire input.** A beat is taken on a cycle where `rt_valid` and `rt_ready` are both high. Non-logged events are taken and discarded. `rt_ready` falls while the staging line is full. The line stays full as long as the previous line write has not been accepted, so the retire side stalls and nothing is lost.
- **Line write output.** Once `wr_valid` rises, it stays high with `wr_line` and `wr_data` unchanged until a cycle with `wr_ready` high.

Top module: `hist_log_rec`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `wr_valid` and `ix_valid` are low and `rt_ready` is high.
- R2: A retire beat is logged only when `rt_kind` is 2'b01 (off-chip miss) or 2'b10 (prefetch hit) and `rt_wrongpath` is 0. Kinds 2'b00 and 2'b11, and any wrong-path beat, are accepted but produce no offer and use no slot.
- R3: Each logged beat gives exactly one `ix_valid` pulse on the next cycle, with `ix_addr` equal to the logged address.
- R4: After `SLOTS` logged beats the block issues one line write. Slot k sits at `wr_data[k*(ADDR_W+1) +: ADDR_W+1]`, with the address in the low `ADDR_W` bits and the end mark in the top bit.
- R5: Line writes carry indices 0, 1, 2, … and wrap to 0 after `LINES-1`. The line part of `ix_ptr` (its upper bits) is the line the entry will be written in.
- R6: When the staging line is full and the previous line write is still pending, `rt_ready` is low, and no beat is lost or dropped.
- R7: While `wr_valid` is high and `wr_ready` is low, on the next cycle `wr_valid` stays high and `wr_line` and `wr_data` are unchanged.
- R8: A mark request (`mk_valid`) sets the end-mark bit of the entry it names, but only when `mk_line` equals the staging line index and `mk_slot` names a slot already filled. Any other mark request leaves every written line unchanged.
- R9: Slots fill in order 0 to `SLOTS-1`. The slot part of `ix_ptr` (its low `$clog2(SLOTS)` bits) is the slot the entry was written to, and is always below `SLOTS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rt_valid | input | 1 | Retire event valid |
| rt_ready | output | 1 | Retire event can be taken |
| rt_kind | input | 2 | 01 miss, 10 prefetch hit, 00/11 not logged |
| rt_wrongpath | input | 1 | Event lies on a wrong path |
| rt_addr | input | ADDR_W | Retired physical address |
| mk_valid | input | 1 | Stream-end mark request |
| mk_line | input | clog2(LINES) | Line index of the entry to mark |
| mk_slot | input | clog2(SLOTS) | Slot index of the entry to mark |
| wr_valid | output | 1 | Line write valid |
| wr_ready | input | 1 | Line write accepted |
| wr_line | output | clog2(LINES) | Log line index being written |
| wr_data | output | SLOTS*(ADDR_W+1) | Packed line of entries |
| ix_valid | output | 1 | Index update offer, one-cycle pulse |
| ix_addr | output | ADDR_W | Address offered to the index table |
| ix_ptr | output | clog2(LINES)+clog2(SLOTS) | Log position {line, slot} |

## Verification
Some properties are checked by assertions on every cycle:

- an offer follows a kept beat and never any other beat;
- a pending line write holds still until accepted;
- line indices advance with wrap;
- the line part of each offer agrees with the pending write;
- the slot part of each offer stays below `SLOTS`.

Other properties are visible only in the bench scenarios: the exact packing of the line, which mark requests land and which are ignored, and the stall that forms when two full lines pile up behind a write the memory side does not accept.

// File: rtl/hlr_pkg.sv
package hlr_pkg;

  typedef enum logic [1:0] {
    KIND_OTHER = 2'b00,
    KIND_MISS  = 2'b01,
    KIND_PFHIT = 2'b10,
    KIND_RSVD  = 2'b11
  } rt_kind_e;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic logic kind_logged(input logic [1:0] kind, input logic wrong);
    return ((kind == KIND_MISS) || (kind == KIND_PFHIT)) && !wrong;
  endfunction

endpackage

// File: rtl/hlr_filter.sv
module hlr_filter
  import hlr_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       wrongpath,
  output logic       keep
);
  always_comb keep = kind_logged(kind, wrongpath);
endmodule

// File: rtl/hlr_stage.sv
module hlr_stage
  import hlr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SLOTS  = 12,
  localparam int SLOT_W = idx_w(SLOTS),
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int EW     = ADDR_W + 1,
  localparam int DW     = SLOTS * EW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              mark_en,
  input  logic [SLOT_W-1:0] mark_slot,
  input  logic              drain,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              full,
  output logic [DW-1:0]     view
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (drain) cnt_q <= '0;
    else if (push)  cnt_q <= cnt_q + 1'b1;
  end

  assign full     = (cnt_q == CNT_W'(SLOTS));
  assign slot_idx = cnt_q[SLOT_W-1:0];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [ADDR_W-1:0] addr_q;
    logic              mark_q;
    logic              sel_push;
    logic              sel_mark;

    assign sel_push = push && (cnt_q == CNT_W'(k));
    assign sel_mark = mark_en && (mark_slot == SLOT_W'(k)) && (CNT_W'(k) < cnt_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        addr_q <= '0;
      else if (sel_push) addr_q <= push_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mark_q <= 1'b0;
      else if (drain)    mark_q <= 1'b0;
      else if (sel_push) mark_q <= 1'b0;
      else if (sel_mark) mark_q <= 1'b1;
    end

    // A mark landing on the transfer edge is folded into the outgoing line.
    assign view[k*EW +: EW] = {mark_q | sel_mark, addr_q};
  end
endmodule

// File: rtl/hlr_lineptr.sv
module hlr_lineptr
  import hlr_pkg::*;
#(
  parameter int LINES = 4,
  localparam int LINE_W = idx_w(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  output logic [LINE_W-1:0] line
);
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else if (advance) begin
      if (line_q == LINE_W'(LINES - 1)) line_q <= '0;
      else                              line_q <= line_q + 1'b1;
    end
  end

  assign line = line_q;
endmodule

// File: rtl/hlr_linewr.sv
module hlr_linewr #(
  parameter int LINE_W = 2,
  parameter int DW     = 396
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LINE_W-1:0] load_line,
  input  logic [DW-1:0]     load_data,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [LINE_W-1:0] wr_line,
  output logic [DW-1:0]     wr_data,
  output logic              free
);
  logic              vld_q;
  logic [LINE_W-1:0] line_q;
  logic [DW-1:0]     data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      line_q <= '0;
      data_q <= '0;
    end else if (load) begin
      vld_q  <= 1'b1;
      line_q <= load_line;
      data_q <= load_data;
    end else if (wr_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign free     = !vld_q || wr_ready;
  assign wr_valid = vld_q;
  assign wr_line  = line_q;
  assign wr_data  = data_q;
endmodule

// File: rtl/hist_log_rec.sv
module hist_log_rec
  import hlr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SLOTS  = 12,
  parameter int LINES  = 4,
  localparam int SLOT_W = idx_w(SLOTS),
  localparam int LINE_W = idx_w(LINES),
  localparam int PTR_W  = LINE_W + SLOT_W,
  localparam int EW     = ADDR_W + 1,
  localparam int DW     = SLOTS * EW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rt_valid,
  output logic              rt_ready,
  input  logic [1:0]        rt_kind,
  input  logic              rt_wrongpath,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic              mk_valid,
  input  logic [LINE_W-1:0] mk_line,
  input  logic [SLOT_W-1:0] mk_slot,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [LINE_W-1:0] wr_line,
  output logic [DW-1:0]     wr_data,
  output logic              ix_valid,
  output logic [ADDR_W-1:0] ix_addr,
  output logic [PTR_W-1:0]  ix_ptr
);
  logic              keep;
  logic              push;
  logic              full;
  logic              out_free;
  logic              drain;
  logic              mark_en;
  logic [SLOT_W-1:0] slot_idx;
  logic [LINE_W-1:0] line_idx;
  logic [DW-1:0]     stage_view;

  hlr_filter i_filter (
    .kind      (rt_kind),
    .wrongpath (rt_wrongpath),
    .keep      (keep)
  );

  assign rt_ready = !full;
  assign push     = rt_valid && rt_ready && keep;
  assign drain    = full && out_free;
  assign mark_en  = mk_valid && (mk_line == line_idx);

  hlr_stage #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) i_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (rt_addr),
    .mark_en   (mark_en),
    .mark_slot (mk_slot),
    .drain     (drain),
    .slot_idx  (slot_idx),
    .full      (full),
    .view      (stage_view)
  );

  hlr_lineptr #(.LINES(LINES)) i_lineptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (drain),
    .line    (line_idx)
  );

  hlr_linewr #(.LINE_W(LINE_W), .DW(DW)) i_linewr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (drain),
    .load_line (line_idx),
    .load_data (stage_view),
    .wr_ready  (wr_ready),
    .wr_valid  (wr_valid),
    .wr_line   (wr_line),
    .wr_data   (wr_data),
    .free      (out_free)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ix_valid <= 1'b0;
      ix_addr  <= '0;
      ix_ptr   <= '0;
    end else begin
      ix_valid <= push;
      if (push) begin
        ix_addr <= rt_addr;
        ix_ptr  <= {line_idx, slot_idx};
      end
    end
  end
endmodule

// File: rtl/hlr_chk.sv
module hlr_chk
  import hlr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SLOTS  = 12,
  parameter int LINES  = 4,
  localparam int SLOT_W = idx_w(SLOTS),
  localparam int LINE_W = idx_w(LINES),
  localparam int PTR_W  = LINE_W + SLOT_W,
  localparam int DW     = SLOTS * (ADDR_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rt_valid,
  input logic              rt_ready,
  input logic [1:0]        rt_kind,
  input logic              rt_wrongpath,
  input logic [ADDR_W-1:0] rt_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [LINE_W-1:0] wr_line,
  input logic [DW-1:0]     wr_data,
  input logic              ix_valid,
  input logic [ADDR_W-1:0] ix_addr,
  input logic [PTR_W-1:0]  ix_ptr
);
  logic              taken_log;
  logic [LINE_W-1:0] exp_line;
  logic [LINE_W-1:0] exp_next;

  assign taken_log = rt_valid && rt_ready &&
                     (rt_kind == 2'b01 || rt_kind == 2'b10) && !rt_wrongpath;
  assign exp_next  = (exp_line == LINE_W'(LINES - 1)) ? '0 : exp_line + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    exp_line <= '0;
    else if (wr_valid && wr_ready) exp_line <= exp_next;
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!wr_valid && !ix_valid)); // R1

  AST_NO_STRAY_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_log |=> !ix_valid); // R2

  AST_OFFER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    taken_log |=> (ix_valid && ix_addr == $past(rt_addr))); // R3

  AST_LINE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_line == exp_line)); // R5

  AST_OFFER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ix_valid |-> (ix_ptr[PTR_W-1:SLOT_W] == (wr_valid ? exp_next : exp_line))); // R5

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_line))); // R7

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ix_valid |-> (int'(ix_ptr[SLOT_W-1:0]) < SLOTS)); // R9
endmodule

bind hist_log_rec hlr_chk #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .LINES(LINES)) i_hlr_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rt_valid     (rt_valid),
  .rt_ready     (rt_ready),
  .rt_kind      (rt_kind),
  .rt_wrongpath (rt_wrongpath),
  .rt_addr      (rt_addr),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_line      (wr_line),
  .wr_data      (wr_data),
  .ix_valid     (ix_valid),
  .ix_addr      (ix_addr),
  .ix_ptr       (ix_ptr)
);

// File: tb/test_hist_log_rec.sv
module test_hist_log_rec;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int SLOTS  = 12;
  localparam int LINES  = 4;
  localparam int SLOT_W = 4;
  localparam int LINE_W = 2;
  localparam int PTR_W  = LINE_W + SLOT_W;
  localparam int EW     = ADDR_W + 1;
  localparam int DW     = SLOTS * EW;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              rt_valid;
  logic              rt_ready;
  logic [1:0]        rt_kind;
  logic              rt_wrongpath;
  logic [ADDR_W-1:0] rt_addr;
  logic              mk_valid;
  logic [LINE_W-1:0] mk_line;
  logic [SLOT_W-1:0] mk_slot;
  logic              wr_valid;
  logic              wr_ready;
  logic [LINE_W-1:0] wr_line;
  logic [DW-1:0]     wr_data;
  logic              ix_valid;
  logic [ADDR_W-1:0] ix_addr;
  logic [PTR_W-1:0]  ix_ptr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hist_log_rec #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .LINES(LINES)) i_hist_log_rec (
    .clk(clk), .rst_n(rst_n),
    .rt_valid(rt_valid), .rt_ready(rt_ready), .rt_kind(rt_kind),
    .rt_wrongpath(rt_wrongpath), .rt_addr(rt_addr),
    .mk_valid(mk_valid), .mk_line(mk_line), .mk_slot(mk_slot),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_line(wr_line), .wr_data(wr_data),
    .ix_valid(ix_valid), .ix_addr(ix_addr), .ix_ptr(ix_ptr)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [ADDR_W-1:0] m_addr [SLOTS];
  logic              m_mark [SLOTS];
  int                m_cnt  = 0;
  int                m_line = 0;
  logic [DW-1:0]     q_data [$];
  int                q_line [$];
  logic              hold_pend = 1'b0;
  logic [DW-1:0]     hold_data;
  logic [LINE_W-1:0] hold_line;

  function automatic logic want_log(input logic [1:0] k, input logic wp);
    return (k == 2'b01 || k == 2'b10) && !wp;
  endfunction

  function automatic logic [DW-1:0] model_line();
    logic [DW-1:0] d = '0;
    for (int k = 0; k < SLOTS; k++) d[k*EW +: EW] = {m_mark[k], m_addr[k]};
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Called just after a falling edge; returns after the next falling edge.
  task automatic cycle(input logic v, input logic [1:0] k, input logic wp,
                       input logic [ADDR_W-1:0] a, input logic mv, input int ml,
                       input int ms, input logic wrr, output logic fired);
    logic keep;
    logic [PTR_W-1:0] eptr;
    logic [DW-1:0] ed;
    int el;
    rt_valid = v; rt_kind = k; rt_wrongpath = wp; rt_addr = a;
    mk_valid = mv; mk_line = LINE_W'(ml); mk_slot = SLOT_W'(ms); wr_ready = wrr;
    #1;
    if (hold_pend)
      chk(wr_valid && wr_data == hold_data && wr_line == hold_line, "R7",
          "stalled line write changed", wr_data, hold_data);
    hold_pend = wr_valid && !wrr;
    hold_data = wr_data;
    hold_line = wr_line;
    if (wr_valid && wrr) begin
      if (q_data.size() == 0) chk(1'b0, "R4", "unexpected line write", wr_data, '0);
      else begin
        ed = q_data.pop_front();
        el = q_line.pop_front();
        chk(wr_data == ed, "R4 R8", "line contents", wr_data, ed);
        chk(int'(wr_line) == el, "R5", "line index", DW'(wr_line), DW'(el));
      end
    end
    fired = v && rt_ready;
    keep  = fired && want_log(k, wp);
    if (mv && rt_ready && ml == m_line && ms < m_cnt) m_mark[ms] = 1'b1;
    eptr = {LINE_W'(m_line), SLOT_W'(m_cnt)};
    if (keep) begin
      m_addr[m_cnt] = a;
      m_mark[m_cnt] = 1'b0;
      m_cnt++;
      if (m_cnt == SLOTS) begin
        q_data.push_back(model_line());
        q_line.push_back(m_line);
        m_cnt  = 0;
        m_line = (m_line + 1) % LINES;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(ix_valid == keep, (v && !fired) ? "R6" : (keep ? "R3" : "R2"),
        "offer presence", DW'(ix_valid), DW'(keep));
    if (keep)
      chk(ix_addr == a && ix_ptr == eptr, "R3 R9", "offer address and position",
          {ix_addr, ix_ptr}, {a, eptr});
  endtask

  task automatic send(input logic [1:0] k, input logic wp, input logic [ADDR_W-1:0] a,
                      input logic wrr);
    logic f;
    for (int t = 0; t < 100; t++) begin
      cycle(1'b1, k, wp, a, 1'b0, 0, 0, wrr, f);
      if (f) break;
    end
  endtask

  task automatic idle(input logic wrr);
    logic f;
    cycle(1'b0, 2'b00, 1'b0, '0, 1'b0, 0, 0, wrr, f);
  endtask

  task automatic mark(input int ml, input int ms);
    logic f;
    cycle(1'b0, 2'b00, 1'b0, '0, 1'b1, ml, ms, 1'b0, f);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic f;
    void'($urandom(32'd20240611));
    for (int k = 0; k < SLOTS; k++) begin m_addr[k] = '0; m_mark[k] = 1'b0; end
    rst_n = 1'b0; rt_valid = 0; rt_kind = 0; rt_wrongpath = 0; rt_addr = 0;
    mk_valid = 0; mk_line = 0; mk_slot = 0; wr_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rt_ready && !wr_valid && !ix_valid, "R1", "reset state",
        DW'({rt_ready, wr_valid, ix_valid}), DW'(3'b100));

    // R2: non-logged kinds and wrong-path beats are consumed silently
    send(2'b00, 1'b0, 32'h1000_0000, 1'b0);
    send(2'b11, 1'b0, 32'h1000_0040, 1'b0);
    send(2'b01, 1'b1, 32'h1000_0080, 1'b0);
    send(2'b10, 1'b1, 32'h1000_00c0, 1'b0);

    // R8: marks on staged, unfilled and foreign-line slots
    send(2'b01, 1'b0, 32'hA000_0000, 1'b0);
    send(2'b10, 1'b0, 32'hA000_0040, 1'b0);
    send(2'b01, 1'b0, 32'hA000_0080, 1'b0);
    mark(0, 1);
    mark(0, 5);
    mark(2, 0);
    mark(0, 14);

    // R6: fill two lines with no write acceptance; the retire side must stall
    for (int i = 3; i < 2 * SLOTS; i++) send(2'b01, 1'b0, 32'hB000_0000 + i * 64, 1'b0);
    for (int i = 0; i < 3; i++) begin
      cycle(1'b1, 2'b01, 1'b0, 32'hDEAD_0000, 1'b0, 0, 0, 1'b0, f);
      chk(!f && !rt_ready, "R6", "staging full with pending write", DW'(rt_ready), '0);
    end
    cycle(1'b1, 2'b01, 1'b0, 32'hDEAD_0000, 1'b0, 0, 0, 1'b1, f);
    send(2'b01, 1'b0, 32'hDEAD_0000, 1'b1);

    // random traffic with wrap of the line index (R5)
    for (int i = 0; i < 1500; i++) begin
      logic v, wp, mv, wrr;
      logic [1:0] k;
      int ml, ms;
      v   = ($urandom % 10) < 7;
      k   = 2'($urandom % 4);
      wp  = ($urandom % 5) == 0;
      mv  = rt_ready && (($urandom % 8) == 0);
      ml  = (($urandom % 4) == 0) ? (m_line + 1) % LINES : m_line;
      ms  = int'($urandom % (SLOTS + 2));
      wrr = ($urandom % 10) < 6;
      cycle(v, k, wp, $urandom, mv, ml, ms, wrr, f);
    end

    for (int i = 0; i < 50 && (q_data.size() != 0 || wr_valid); i++) idle(1'b1);
    chk(q_data.size() == 0 && !wr_valid, "R4", "all full lines written",
        DW'(q_data.size()), '0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule